// File: doc/BRIEF.md
# Floating-Point Exception Flag Unit

This block sits beside a single-precision arithmetic datapath and decides, for each add, subtract, multiply or divide, which exception is recorded, whether the datapath's rounded result may be committed, whether a quiet NaN must be committed in its place, and whether a trap is requested. It looks at the two operands to spot invalid operations and division by zero. It then looks at the raw rounding status reported by the datapath, and weighs all of this against five enable bits held in a small control register.

The control register is ten bits wide. Bits [4:0] are the enables and bits [9:5] are the causes. Within each five-bit field the flag order, from the low bit up, is inexact (I), underflow (U), overflow (O), divide-by-zero (Z), invalid (V). A register-write port loads the whole register. Every operation clears the cause field and records at most one new cause. Results appear one clock after the operation strobe.

Top module: `fpx_flag_unit`

## Requirements
- R1: While reset is held, and after it is released, the control register is all zeros, and `res_valid`, `wb_en`, `qnan_sel` and `trap_req` are low. With every enable cleared, an invalid operation therefore takes the quiet-NaN path.
- R2: A `cfg_we` pulse loads `cfg_wdata` into the register: enables from bits [4:0], causes from bits [9:5], flag order I,U,O,Z,V from bit 0. The loaded causes appear on `cause` one cycle later. If an operation is strobed in the same cycle, that operation is judged with the enables held before the write, the enables take the written value, and the cause field takes the operation's result.
- R3: Operand classes follow the IEEE single layout (sign 31, exponent 30:23, mantissa 22:0). An all-ones exponent with a zero mantissa is infinity. An all-ones exponent with mantissa bit 22 clear and a nonzero mantissa is a signalling NaN. An all-ones exponent with mantissa bit 22 set is a quiet NaN, which is not invalid by itself. A zero exponent, including a denormal, counts as zero.
- R4: Opcodes are 00 add, 01 sub, 10 mul, 11 div. An operation is invalid when either operand is a signalling NaN, or in any of these cases: add of infinities of opposite sign, sub of infinities of equal sign, mul of infinity by zero in either order, div of infinity by infinity, div of zero by zero.
- R5: An invalid operation with the V enable set sets only the V cause, and `wb_en` and `qnan_sel` stay low.
- R6: An invalid operation with the V enable clear raises `wb_en` and `qnan_sel` together and leaves all causes clear.
- R7: A div whose dividend is finite and nonzero and whose divisor is zero sets only the Z cause and suppresses write-back when the Z enable is set. With the Z enable clear, it falls through to status resolution.
- R8: The raw status bits are: 0 inexact, 1 rounded, 2 underflow, 3 denormal, 4 overflow. They are resolved first-match. Overflow with O enabled sets O. Otherwise, underflow or denormal with U enabled sets U. Otherwise, inexact or rounded with I enabled sets I. A match suppresses write-back.
- R9: When no enabled condition matches, `wb_en` is high, `qnan_sel` is low and no cause is set.
- R10: Each operation clears the previous causes, so after an operation at most one cause bit is set.
- R11: `trap_req` is high exactly in the result cycle of an operation whose cause field is nonzero.
- R12: Results appear, with `res_valid` high, on the cycle after `op_valid`. In cycles with no result, `wb_en`, `qnan_sel` and `trap_req` are low and `cause` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 10 | Control register write data (causes [9:5], enables [4:0]) |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | Operation: 00 add, 01 sub, 10 mul, 11 div |
| opnd_a | input | 32 | First operand, IEEE single |
| opnd_b | input | 32 | Second operand, IEEE single |
| raw_status | input | 5 | Datapath rounding status |
| res_valid | output | 1 | Result cycle marker |
| cause | output | 5 | Cause field of the control register |
| wb_en | output | 1 | Commit the result |
| qnan_sel | output | 1 | Commit a quiet NaN instead of the result |
| trap_req | output | 1 | Trap request |

## Verification
Directed operand pairs cover each invalid rule against near-miss neighbours. Infinities of equal sign under add are one such neighbour. A quiet NaN is another, as are denormals standing in for zero and infinity divided by zero. These separate a correct operand classification from one that confuses zero with denormal or quiet with signalling NaNs. Status vectors with several bits set under different enable masks expose a wrong priority or a chain that fails to fall through to the next condition. Random operands drawn from a class palette, with random status and changing enables, then exercise the interaction of all paths, including a register write coinciding with an operation.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_N   = 5;
  localparam int CTL_W    = 2 * FLAG_N;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int DATA_W   = EXP_W + MAN_W + 1;

  // flag positions inside enable and cause fields
  localparam int FX_I = 0;
  localparam int FX_U = 1;
  localparam int FX_O = 2;
  localparam int FX_Z = 3;
  localparam int FX_V = 4;

  // raw status positions
  localparam int ST_N       = 5;
  localparam int ST_INEXACT = 0;
  localparam int ST_ROUNDED = 1;
  localparam int ST_UNDER   = 2;
  localparam int ST_DENORM  = 3;
  localparam int ST_OVER    = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } fpx_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic snan;
    logic finite_nz;
  } fpx_class_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] opnd,
  output fpx_class_t     cls
);
  localparam logic [EW-1:0] EXP_ONES = {EW{1'b1}};

  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;
  logic          exp_max;
  logic          exp_min;

  always_comb begin
    exp_f   = opnd[EW+MW-1:MW];
    man_f   = opnd[MW-1:0];
    exp_max = (exp_f == EXP_ONES);
    exp_min = (exp_f == '0);
    cls.sign      = opnd[EW+MW];
    // denormals are flushed: any zero exponent counts as zero
    cls.zero      = exp_min;
    cls.inf       = exp_max && (man_f == '0);
    cls.snan      = exp_max && !man_f[MW-1] && (man_f != '0);
    cls.finite_nz = !exp_max && !exp_min;
  end
endmodule

// File: rtl/fpx_decide.sv
module fpx_decide
  import fpx_pkg::*;
(
  input  fpx_op_e           op,
  input  fpx_class_t        cls_a,
  input  fpx_class_t        cls_b,
  input  logic [ST_N-1:0]   status,
  input  logic [FLAG_N-1:0] enables,
  output logic [FLAG_N-1:0] cause_nxt,
  output logic              wb_nxt,
  output logic              qnan_nxt
);
  logic invalid_op;
  logic div_by_zero;
  logic both_inf;

  always_comb begin
    both_inf = cls_a.inf && cls_b.inf;
    unique case (op)
      OP_ADD:  invalid_op = both_inf && (cls_a.sign != cls_b.sign);
      OP_SUB:  invalid_op = both_inf && (cls_a.sign == cls_b.sign);
      OP_MUL:  invalid_op = (cls_a.inf && cls_b.zero) || (cls_a.zero && cls_b.inf);
      OP_DIV:  invalid_op = both_inf || (cls_a.zero && cls_b.zero);
      default: invalid_op = 1'b0;
    endcase
    invalid_op  = invalid_op || cls_a.snan || cls_b.snan;
    div_by_zero = (op == OP_DIV) && cls_a.finite_nz && cls_b.zero;
  end

  always_comb begin
    cause_nxt = '0;
    wb_nxt    = 1'b0;
    qnan_nxt  = 1'b0;
    if (invalid_op) begin
      if (enables[FX_V]) begin
        cause_nxt[FX_V] = 1'b1;
      end else begin
        wb_nxt   = 1'b1;
        qnan_nxt = 1'b1;
      end
    end else if (div_by_zero && enables[FX_Z]) begin
      cause_nxt[FX_Z] = 1'b1;
    end else if (status[ST_OVER] && enables[FX_O]) begin
      cause_nxt[FX_O] = 1'b1;
    end else if ((status[ST_UNDER] || status[ST_DENORM]) && enables[FX_U]) begin
      cause_nxt[FX_U] = 1'b1;
    end else if ((status[ST_INEXACT] || status[ST_ROUNDED]) && enables[FX_I]) begin
      cause_nxt[FX_I] = 1'b1;
    end else begin
      wb_nxt = 1'b1;
    end
  end
endmodule

// File: rtl/fpx_ctl_reg.sv
module fpx_ctl_reg
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTL_W-1:0]  cfg_wdata,
  input  logic              op_done,
  input  logic [FLAG_N-1:0] cause_in,
  output logic [FLAG_N-1:0] en_q,
  output logic [FLAG_N-1:0] cause_q
);
  logic [FLAG_N-1:0] en_d;
  logic [FLAG_N-1:0] cause_d;
  logic              en_ce;
  logic              cause_ce;

  always_comb begin
    en_ce    = cfg_we;
    en_d     = cfg_wdata[FLAG_N-1:0];
    cause_ce = cfg_we || op_done;
    // an operation overrides a simultaneous cause write
    cause_d  = op_done ? cause_in : cfg_wdata[CTL_W-1:FLAG_N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      cause_q <= '0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (cause_ce) cause_q <= cause_d;
    end
  end

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> en_q == $past(cfg_wdata[FLAG_N-1:0])); // R2
  AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !op_done) |=> cause_q == $past(cfg_wdata[CTL_W-1:FLAG_N])); // R2
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !op_done) |=> $stable(cause_q)); // R12
endmodule

// File: rtl/fpx_flag_unit.sv
module fpx_flag_unit
  import fpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CTL_W-1:0]   cfg_wdata,
  input  logic               op_valid,
  input  logic [1:0]         op_code,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic [ST_N-1:0]    raw_status,
  output logic               res_valid,
  output logic [FLAG_N-1:0]  cause,
  output logic               wb_en,
  output logic               qnan_sel,
  output logic               trap_req
);
  localparam int SYNC_N = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_N-1];

  fpx_class_t        cls [2];
  logic [DATA_W-1:0] opnds [2];
  assign opnds[0] = opnd_a;
  assign opnds[1] = opnd_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpx_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls (
      .opnd (opnds[gi]),
      .cls  (cls[gi])
    );
  end

  logic [FLAG_N-1:0] en_q;
  logic [FLAG_N-1:0] cause_nxt;
  logic              wb_nxt;
  logic              qnan_nxt;

  fpx_decide u_decide (
    .op        (fpx_op_e'(op_code)),
    .cls_a     (cls[0]),
    .cls_b     (cls[1]),
    .status    (raw_status),
    .enables   (en_q),
    .cause_nxt (cause_nxt),
    .wb_nxt    (wb_nxt),
    .qnan_nxt  (qnan_nxt)
  );

  fpx_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .op_done   (op_valid),
    .cause_in  (cause_nxt),
    .en_q      (en_q),
    .cause_q   (cause)
  );

  logic vld_d, wb_d, qnan_d, trap_d;

  always_comb begin
    vld_d  = op_valid;
    wb_d   = op_valid && wb_nxt;
    qnan_d = op_valid && qnan_nxt;
    trap_d = op_valid && (cause_nxt != '0);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_valid <= 1'b0;
      wb_en     <= 1'b0;
      qnan_sel  <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      res_valid <= vld_d;
      wb_en     <= wb_d;
      qnan_sel  <= qnan_d;
      trap_req  <= trap_d;
    end
  end

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    res_valid |-> $onehot0(cause)); // R10
  AST_WB_VS_CAUSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    res_valid |-> (wb_en == (cause == '0))); // R9
  AST_QNAN_WB: assert property (@(posedge clk) disable iff (!rst_s_n)
    qnan_sel |-> (wb_en && cause == '0)); // R6
  AST_TRAP_MATCH: assert property (@(posedge clk) disable iff (!rst_s_n)
    res_valid |-> (trap_req == (cause != '0))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    !res_valid |-> (!wb_en && !qnan_sel && !trap_req)); // R12
  AST_RES_TIMING: assert property (@(posedge clk) disable iff (!rst_s_n)
    op_valid |=> res_valid); // R12
endmodule

// File: tb/fpx_flag_unit_tb.sv
module fpx_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [9:0]  cfg_wdata;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic [4:0]  raw_status;
  logic        res_valid, wb_en, qnan_sel, trap_req;
  logic [4:0]  cause;

  int checks = 0;
  int errors = 0;
  logic [4:0] en_m;

  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;
  localparam logic [31:0] SNAN = 32'h7F80_0001;
  localparam logic [31:0] ONE  = 32'h3F80_0000;
  localparam logic [31:0] PZ   = 32'h0000_0000;
  localparam logic [31:0] DEN  = 32'h0000_0001;

  always #10 clk = ~clk;

  fpx_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .op_valid(op_valid), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .raw_status(raw_status), .res_valid(res_valid), .cause(cause),
    .wb_en(wb_en), .qnan_sel(qnan_sel), .trap_req(trap_req)
  );

  function automatic logic is_inf(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] == 0;
  endfunction
  function automatic logic is_snan(input logic [31:0] v);
    return v[30:23] == 8'hFF && !v[22] && v[21:0] != 0;
  endfunction
  function automatic logic is_zero(input logic [31:0] v);
    return v[30:23] == 8'h00;
  endfunction

  // returns {cause[4:0], wb, qnan}
  function automatic logic [6:0] model(input logic [1:0] op, input logic [31:0] a,
                                       input logic [31:0] b, input logic [4:0] st,
                                       input logic [4:0] en);
    logic inv, dz;
    inv = is_snan(a) || is_snan(b);
    case (op)
      2'b00: inv |= is_inf(a) && is_inf(b) && (a[31] != b[31]);
      2'b01: inv |= is_inf(a) && is_inf(b) && (a[31] == b[31]);
      2'b10: inv |= (is_inf(a) && is_zero(b)) || (is_zero(a) && is_inf(b));
      default: inv |= (is_inf(a) && is_inf(b)) || (is_zero(a) && is_zero(b));
    endcase
    dz = (op == 2'b11) && !is_zero(a) && a[30:23] != 8'hFF && is_zero(b);
    if (inv) return en[4] ? {5'b10000, 2'b00} : {5'b00000, 2'b11};
    if (dz && en[3]) return {5'b01000, 2'b00};
    if (st[4] && en[2]) return {5'b00100, 2'b00};
    if ((st[2] || st[3]) && en[1]) return {5'b00010, 2'b00};
    if ((st[0] || st[1]) && en[0]) return {5'b00001, 2'b00};
    return {5'b00000, 2'b10};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] st, input string tag);
    logic [6:0] e;
    e = model(op, a, b, st, en_m);
    op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; raw_status = st;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    check(tag, {res_valid, cause, wb_en, qnan_sel, trap_req},
          {1'b1, e[6:2], e[1], e[0], |e[6:2]});
  endtask

  task automatic do_cfg(input logic [9:0] w, input string tag);
    cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    en_m = w[4:0];
    check(tag, {res_valid, cause, wb_en, qnan_sel, trap_req}, {1'b0, w[9:5], 3'b000});
  endtask

  function automatic logic [31:0] pick_opnd();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 6)
      0: return {r[31], 31'h0};
      1: return {r[31], 8'h00, r[22:0] | 23'h1};
      2: return {r[31], 8'hFF, 23'h0};
      3: return {r[31], 8'hFF, 1'b1, r[21:0]};
      4: return {r[31], 8'hFF, 1'b0, r[21:0] | 22'h1};
      default: return {r[31], 8'h7F ^ {4'h0, r[26:23]}, r[22:0]};
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; op_valid = 1'b0;
    op_code = '0; opnd_a = '0; opnd_b = '0; raw_status = '0; en_m = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", {res_valid, cause, wb_en, qnan_sel, trap_req}, 9'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {res_valid, cause, wb_en, qnan_sel, trap_req}, 9'h0);
    do_op(2'b00, PINF, NINF, 5'h00, "R1 R6 enables cleared, invalid gives qnan");

    do_cfg({5'h1F, 5'h1F}, "R2 load causes and enables");
    do_op(2'b00, PINF, NINF, 5'h00, "R5 R4 add opposite inf");
    do_op(2'b00, PINF, PINF, 5'h00, "R4 R9 add equal inf is valid");
    do_op(2'b01, NINF, NINF, 5'h00, "R4 sub equal inf");
    do_op(2'b01, PINF, NINF, 5'h00, "R4 R9 sub opposite inf is valid");
    do_op(2'b10, PINF, PZ,   5'h00, "R4 mul inf by zero");
    do_op(2'b10, DEN,  NINF, 5'h00, "R3 R4 mul denormal by inf");
    do_op(2'b11, PINF, NINF, 5'h00, "R4 div inf by inf");
    do_op(2'b11, PZ,   PZ,   5'h00, "R4 div zero by zero");
    do_op(2'b11, DEN,  PZ,   5'h00, "R3 div denormal by zero");
    do_op(2'b00, SNAN, ONE,  5'h00, "R3 R4 snan operand");
    do_op(2'b00, ONE,  QNAN, 5'h00, "R3 qnan operand not invalid");
    do_op(2'b11, ONE,  PZ,   5'h1F, "R7 div by zero enabled");
    do_op(2'b11, PINF, PZ,   5'h00, "R7 inf by zero not div-by-zero");
    do_op(2'b00, ONE,  ONE,  5'h1F, "R8 overflow first");
    do_op(2'b00, ONE,  ONE,  5'h00, "R10 causes cleared");
    do_cfg({5'h00, 5'h13}, "R2 enables I U V");
    do_op(2'b11, ONE,  PZ,   5'h00, "R7 div by zero disabled falls through");
    do_op(2'b00, ONE,  ONE,  5'h1F, "R8 overflow disabled falls to U");
    do_op(2'b00, ONE,  ONE,  5'h08, "R8 denormal status gives U");
    do_op(2'b00, ONE,  ONE,  5'h02, "R8 rounded status gives I");
    do_cfg({5'h00, 5'h01}, "R2 only I enabled");
    do_op(2'b10, ONE,  ONE,  5'h1F, "R8 all status, only I enabled");
    do_op(2'b01, PINF, PINF, 5'h00, "R6 invalid disabled");
    do_cfg({5'h00, 5'h00}, "R2 clear all");
    do_op(2'b10, ONE,  ONE,  5'h1F, "R9 no enabled match");
    // idle cycle: nothing strobed, cause holds
    @(posedge clk); @(negedge clk);
    check("R12 idle", {res_valid, cause, wb_en, qnan_sel, trap_req}, 9'h0);

    // simultaneous write and operation: old enables judge the op
    do_cfg({5'h00, 5'h10}, "R2 enable V");
    cfg_we = 1'b1; cfg_wdata = {5'h1F, 5'h00};
    op_valid = 1'b1; op_code = 2'b11; opnd_a = PZ; opnd_b = PZ; raw_status = '0;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; op_valid = 1'b0; en_m = 5'h00;
    check("R2 R11 op wins causes, old enables", {res_valid, cause, wb_en, qnan_sel, trap_req},
          {1'b1, 5'b10000, 3'b001});
    do_op(2'b11, PZ, PZ, 5'h00, "R2 new enables after combined write");

    for (int i = 0; i < 600; i++) begin
      if ($urandom % 16 == 0)
        do_cfg({5'($urandom), 5'($urandom)}, "R2 random config");
      do_op(2'($urandom), pick_opnd(), pick_opnd(), 5'($urandom), "R4 R8 random op");
      if ($urandom % 8 == 0) begin
        logic [4:0] held;
        held = cause;
        @(posedge clk); @(negedge clk);
        check("R12 random idle", {res_valid, cause, wb_en, qnan_sel, trap_req}, {1'b0, held, 3'b000});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule